// File: doc/BRIEF.md
# Multi-mode mantissa rounding stage

This block rounds an internal floating-point mantissa that carries two extra low-order bits below its least significant kept bit, plus a sticky flag that summarises every bit already shifted out further down. In one clock it discards those two extra bits, decides from the selected rounding direction and the operand sign whether to add one at the new least significant position, and registers the result. It also reports whether an increment was applied and whether any precision was lost.

Packing logic downstream uses the rounded-up flag to detect a carry into a new leading bit. An all-ones mantissa that rounds up simply carries through every bit. Exponent adjustment and exception trapping belong to the consumer. The stage has no stall: every cycle with `in_valid` high produces one result on the following cycle.

Top module: `mant_round`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no input accepted, `out_valid`, `rounded_up`, `inexact` and `mant_out` are all zero.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. Each result appears one cycle after its operands.
- R3: `mant_out` equals `mant_in` shifted right by two (bits 1 and 0 dropped) plus one when `rounded_up` is high, taken modulo 2^(W-2). `rounded_up` is high exactly when that increment was applied.
- R4: When bit 1 (guard), bit 0 (round) and `sticky_in` are all zero, no increment is applied and `inexact` is low, whatever the mode.
- R5: When any of guard, round or `sticky_in` is set, `inexact` is high, whatever the mode.
- R6: With `mode_in` = 2'b00 (nearest, ties to even), the increment is applied when guard is set and at least one of round, sticky or bit 2 of `mant_in` (the kept LSB) is set.
- R7: With `mode_in` = 2'b01 (toward zero), no increment is ever applied.
- R8: With `mode_in` = 2'b10 (toward minus infinity), the increment is applied exactly when the result is inexact and `sign_in` is 1 (negative).
- R9: With `mode_in` = 2'b11 (toward plus infinity), the increment is applied exactly when the result is inexact and `sign_in` is 0 (positive).
- R10: The carry of the increment propagates across the whole output width: a run of ones at the kept LSB and above clears, and the next zero bit up is set, even at the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on the inputs are to be rounded this cycle |
| mant_in | input | W | Mantissa; bit 1 is guard and bit 0 is round |
| sign_in | input | 1 | Operand sign, 1 = negative |
| sticky_in | input | 1 | OR of all bits lost below the round bit |
| mode_in | input | 2 | Rounding direction: 00 nearest, 01 to zero, 10 to minus infinity, 11 to plus infinity |
| out_valid | output | 1 | Registered result is valid |
| mant_out | output | W-2 | Rounded mantissa without guard and round bits |
| rounded_up | output | 1 | An increment was applied |
| inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The assertions assume that `in_valid`, `mode_in`, `sign_in`, `sticky_in` and `mant_in` are known values whenever the block is out of reset, and that `in_valid` is held low during reset. Their one-cycle lookbacks therefore never read a value from before reset. The bench drives every input on the falling edge and keeps `in_valid` low until reset ends. It sweeps every mantissa, sign, sticky and mode combination of an 8-bit instance, so no input leaves this range. A second instance at the default width drives only full-width carry patterns.

// File: rtl/mant_round.sv
module mant_round #(
  parameter int W = 66
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] mant_in,
  input  logic         sign_in,
  input  logic         sticky_in,
  input  logic [1:0]   mode_in,
  output logic         out_valid,
  output logic [W-3:0] mant_out,
  output logic         rounded_up,
  output logic         inexact
);
  localparam int OW = W - 2;

  localparam logic [1:0] M_NEAR = 2'b00;
  localparam logic [1:0] M_ZERO = 2'b01;
  localparam logic [1:0] M_NINF = 2'b10;
  localparam logic [1:0] M_PINF = 2'b11;

  logic [OW-1:0] kept;
  logic          g_bit, r_bit, lost, bump;
  logic [OW-1:0] next_mant;

  assign kept  = mant_in[W-1:2];
  assign g_bit = mant_in[1];
  assign r_bit = mant_in[0];
  assign lost  = g_bit | r_bit | sticky_in;

  always_comb begin
    case (mode_in)
      M_NEAR:  bump = g_bit & (r_bit | sticky_in | kept[0]);
      M_ZERO:  bump = 1'b0;
      M_NINF:  bump = lost & sign_in;
      M_PINF:  bump = lost & ~sign_in;
      default: bump = 1'b0;
    endcase
  end

  assign next_mant = kept + {{(OW-1){1'b0}}, bump};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      mant_out   <= '0;
      rounded_up <= 1'b0;
      inexact    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mant_out   <= next_mant;
        rounded_up <= bump;
        inexact    <= lost;
      end
    end
  end

  // R2
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> mant_out == $past(mant_in[W-1:2]) + {{(OW-1){1'b0}}, rounded_up});
  // R4
  p_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mant_in[1:0] == 2'b00 && !sticky_in) |=> (!inexact && !rounded_up));
  // R5
  p_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mant_in[1:0] != 2'b00 || sticky_in)) |=> inexact);
  // R6: nearest never rounds up with guard clear
  p_near_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == M_NEAR && !mant_in[1]) |=> !rounded_up);
  // R7
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == M_ZERO) |=> !rounded_up);
  // R8
  p_ninf_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == M_NINF && !sign_in) |=> !rounded_up);
  // R9
  p_pinf_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == M_PINF && sign_in) |=> !rounded_up);
  // R5 with R3: an increment only follows lost precision
  p_up_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rounded_up |-> inexact);
endmodule

// File: tb/mant_round_test.sv
`timescale 1ns/1ps
module mant_round_test;
  localparam int SW = 8;
  localparam int LW = 66;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [SW-1:0] mant_in = '0;
  logic          sign_in = 1'b0, sticky_in = 1'b0;
  logic [1:0]    mode_in = 2'b00;
  logic          out_valid, rounded_up, inexact;
  logic [SW-3:0] mant_out;

  logic          w_valid = 1'b0;
  logic [LW-1:0] w_mant = '0;
  logic          w_sign = 1'b0, w_sticky = 1'b0;
  logic [1:0]    w_mode = 2'b00;
  logic          w_ovalid, w_up, w_inex;
  logic [LW-3:0] w_out;

  mant_round #(.W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mant_in(mant_in),
    .sign_in(sign_in), .sticky_in(sticky_in), .mode_in(mode_in),
    .out_valid(out_valid), .mant_out(mant_out), .rounded_up(rounded_up),
    .inexact(inexact));

  mant_round #(.W(LW)) uut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .mant_in(w_mant),
    .sign_in(w_sign), .sticky_in(w_sticky), .mode_in(w_mode),
    .out_valid(w_ovalid), .mant_out(w_out), .rounded_up(w_up),
    .inexact(w_inex));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 0);
    chk("R1 mant_out", 64'(mant_out), 0);
    chk("R1 rounded_up", 64'(rounded_up), 0);
    chk("R1 inexact", 64'(inexact), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 64'(out_valid), 0);
    chk("R1 inexact after reset", 64'(inexact), 0);

    for (int md = 0; md < 4; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int st = 0; st < 2; st++) begin
          for (int m = 0; m < (1 << SW); m++) begin
            int q, rem, up, lossy, expm;
            string tag;
            q = m >> 2;
            rem = m & 3;
            lossy = (rem != 0 || st != 0) ? 1 : 0;
            case (md)
              0: begin
                up = (rem == 3 || (rem == 2 && (st != 0 || (q % 2) == 1))) ? 1 : 0;
                tag = "R6";
              end
              1: begin up = 0; tag = "R7"; end
              2: begin up = (lossy != 0 && sg == 1) ? 1 : 0; tag = "R8"; end
              default: begin up = (lossy != 0 && sg == 0) ? 1 : 0; tag = "R9"; end
            endcase
            expm = (q + up) % (1 << (SW - 2));
            in_valid = 1'b1;
            mant_in = SW'(m);
            sign_in = sg[0];
            sticky_in = st[0];
            mode_in = md[1:0];
            @(negedge clk);
            chk("R2 out_valid", 64'(out_valid), 1);
            chk({tag, " rounded_up"}, 64'(rounded_up), 64'(up));
            chk(lossy != 0 ? "R5 inexact" : "R4 inexact", 64'(inexact), 64'(lossy));
            chk(q == (1 << (SW - 2)) - 1 && up != 0 ? "R10 mant_out" : "R3 mant_out",
                64'(mant_out), 64'(expm));
          end
        end
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 out_valid idle", 64'(out_valid), 0);

    // R10 on the default width: tie with odd LSB carries to the MSB
    w_valid = 1'b1;
    w_mant = {2'b00, {(LW-4){1'b1}}, 2'b10};
    w_mode = 2'b00;
    @(negedge clk);
    chk("R10 wide up", 64'(w_up), 1);
    chk("R10 wide upper", 64'(w_out[LW-3:LW-4]), 64'(2'b01));
    chk("R10 wide lower", w_out[63:0] & ~(64'h3 << 62), 0);
    w_mant = '1;
    w_mode = 2'b11;
    @(negedge clk);
    chk("R10 wide wrap", 64'(|w_out), 0);
    chk("R10 wide wrap up", 64'(w_up), 1);
    w_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule